// File: doc/BRIEF.md
# Three-Window Address Decoder with Write Protection

This block sits between a 16-bit memory bus and a 24K on-board RAM built as three 8K windows. Each window has its own 3-bit base value, compared with the top three address bits, so it can sit on any 8K boundary from 0000h to E000h. Bases need not be consecutive, and two or more windows may share a base. When a read or write cycle falls inside an enabled window, the block asserts that window's chip-select and a board-select. It also passes the RAM the in-window offset and a 2-bit window index. During a write it raises the RAM write strobe, but only if that window is write-enabled.

Two conditions keep the whole board off the bus. The first is an inactive bank-select state. The second is an asserted active-low phantom line while phantom honoring is switched on. Overlapping windows are resolved by fixed priority, so at most one chip-select is ever active. All outputs are registered and appear one clock after the bus inputs are sampled. The RAM array itself lies outside the block.

Top module: `tri_window_decoder`

## Requirements
- R1: While `rst` is high at a clock edge, every output (`win_cs`, `board_sel`, `ram_we`, `win_idx`, `ram_offset`) is zero after that edge.
- R2: One clock after a read or write cycle is sampled, `win_cs[k]` is high exactly when `addr[15:13]` equals window k's base `win_base[3k+2:3k]` and no lower-numbered window also matches. `board_sel` is high exactly when some `win_cs` bit is high.
- R3: When several windows share a base, the lowest index wins (A = bit 0 over B = bit 1 over C = bit 2). `win_cs` is never more than one-hot.
- R4: With a window selected, `win_idx` holds its number (A = 0, B = 1, C = 2) and `ram_offset` holds `addr[12:0]` of the sampled cycle. `ram_offset` follows `addr[12:0]` on every non-reset cycle. `win_idx` is 0 when nothing is selected.
- R5: `ram_we` is high only for a selected write cycle whose window has `win_wr_en[k]` = 1. A write to a protected window raises no strobe and leaves the stored data unchanged, while reads of that window still select it.
- R6: With `phantom_honor` = 1 and `phantom_n` = 0, no window is selected and no strobe is raised.
- R7: With `phantom_honor` = 0, the level of `phantom_n` has no effect on any output.
- R8: With `board_active` = 0, no window is selected and no strobe is raised.
- R9: A cycle with both `mem_read` and `mem_write` low selects nothing.
- R10: With bases A = 1, B = 2, C = 3, addresses 2000h–3FFFh select A, 4000h–5FFFh select B, 6000h–7FFFh select C, and addresses outside 2000h–7FFFh select nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 16 | Bus address |
| mem_read | input | 1 | Memory read cycle in progress |
| mem_write | input | 1 | Memory write cycle in progress |
| board_active | input | 1 | Bank-select state: 1 means the board may respond |
| phantom_n | input | 1 | Active-low phantom bus line |
| phantom_honor | input | 1 | 1 = deselect while phantom_n is low |
| win_base | input | 9 | Window bases, window k at bits [3k+2:3k] |
| win_wr_en | input | 3 | Per-window write enable, bit k for window k |
| win_cs | output | 3 | Registered per-window chip-select |
| board_sel | output | 1 | Registered board-select |
| ram_we | output | 1 | Registered gated write strobe |
| win_idx | output | 2 | Index of the selected window |
| ram_offset | output | 13 | Offset inside the window |

## Verification
The properties assume that `mem_read` and `mem_write` are never high in the same cycle. They also assume that every input holds a known value from the first clock edge on, and that `rst` is high for at least one edge. The stimulus drives all inputs at the falling edge from the start, keeps reset high for several edges, and only ever issues idle, read-only or write-only cycles. Configuration inputs change only between sweeps, so every sampled cycle pairs one bus access with a single stable set of bases, enables and gate settings.

// File: rtl/tri_window_decoder_pkg.sv
package tri_window_decoder_pkg;

  typedef enum logic [1:0] {
    ACC_IDLE  = 2'd0,
    ACC_READ  = 2'd1,
    ACC_WRITE = 2'd2
  } acc_kind_e;

  // A write request takes precedence if both strobes are seen together.
  function automatic acc_kind_e classify_access(input logic rd, input logic wr);
    if (wr)      return ACC_WRITE;
    else if (rd) return ACC_READ;
    else         return ACC_IDLE;
  endfunction

  // Board may answer only when active and not overridden by phantom.
  function automatic logic board_gate(input logic active, input logic ph_n,
                                      input logic honor);
    return active & ~(honor & ~ph_n);
  endfunction

endpackage

// File: rtl/win_match.sv
module win_match #(
  parameter int BASE_W  = 3,
  parameter int NUM_WIN = 3
) (
  input  logic [BASE_W-1:0]         page,
  input  logic [NUM_WIN*BASE_W-1:0] bases,
  output logic [NUM_WIN-1:0]        hit
);

  for (genvar g = 0; g < NUM_WIN; g++) begin : g_cmp
    assign hit[g] = (page == bases[g*BASE_W +: BASE_W]);
  end

endmodule

// File: rtl/win_prio.sv
module win_prio #(
  parameter int NUM_WIN = 3,
  parameter int IDX_W   = 2
) (
  input  logic [NUM_WIN-1:0] hit,
  output logic [NUM_WIN-1:0] grant,
  output logic [IDX_W-1:0]   idx,
  output logic               any
);

  // Scan from the top so that the lowest matching index is left standing.
  always_comb begin
    grant = '0;
    idx   = '0;
    for (int k = NUM_WIN - 1; k >= 0; k--) begin
      if (hit[k]) begin
        grant    = '0;
        grant[k] = 1'b1;
        idx      = IDX_W'(k);
      end
    end
  end

  assign any = |hit;

endmodule

// File: rtl/tri_window_decoder.sv
module tri_window_decoder
  import tri_window_decoder_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int WIN_ADDR_W = 13,
  parameter int NUM_WIN    = 3,
  localparam int BASE_W    = ADDR_W - WIN_ADDR_W,
  localparam int IDX_W     = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [ADDR_W-1:0]         addr,
  input  logic                      mem_read,
  input  logic                      mem_write,
  input  logic                      board_active,
  input  logic                      phantom_n,
  input  logic                      phantom_honor,
  input  logic [NUM_WIN*BASE_W-1:0] win_base,
  input  logic [NUM_WIN-1:0]        win_wr_en,
  output logic [NUM_WIN-1:0]        win_cs,
  output logic                      board_sel,
  output logic                      ram_we,
  output logic [IDX_W-1:0]          win_idx,
  output logic [WIN_ADDR_W-1:0]     ram_offset
);

  logic [NUM_WIN-1:0] hit;
  logic [NUM_WIN-1:0] grant;
  logic [IDX_W-1:0]   grant_idx;
  logic               any_hit;
  logic               gate_ok;
  acc_kind_e          acc;
  logic               sel_d;
  logic               we_d;

  win_match #(
    .BASE_W  (BASE_W),
    .NUM_WIN (NUM_WIN)
  ) u_match (
    .page  (addr[ADDR_W-1 -: BASE_W]),
    .bases (win_base),
    .hit   (hit)
  );

  win_prio #(
    .NUM_WIN (NUM_WIN),
    .IDX_W   (IDX_W)
  ) u_prio (
    .hit   (hit),
    .grant (grant),
    .idx   (grant_idx),
    .any   (any_hit)
  );

  always_comb begin
    gate_ok = board_gate(board_active, phantom_n, phantom_honor);
    acc     = classify_access(mem_read, mem_write);
    sel_d   = gate_ok && any_hit && (acc != ACC_IDLE);
    we_d    = sel_d && (acc == ACC_WRITE) && |(grant & win_wr_en);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      win_cs     <= '0;
      board_sel  <= 1'b0;
      ram_we     <= 1'b0;
      win_idx    <= '0;
      ram_offset <= '0;
    end else begin
      win_cs     <= sel_d ? grant : '0;
      board_sel  <= sel_d;
      ram_we     <= we_d;
      win_idx    <= sel_d ? grant_idx : '0;
      ram_offset <= addr[WIN_ADDR_W-1:0];
    end
  end

endmodule

// File: rtl/tri_window_decoder_chk.sv
module tri_window_decoder_chk #(
  parameter int ADDR_W     = 16,
  parameter int WIN_ADDR_W = 13,
  parameter int NUM_WIN    = 3,
  localparam int BASE_W    = ADDR_W - WIN_ADDR_W,
  localparam int IDX_W     = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1
) (
  input logic                      clk,
  input logic                      rst,
  input logic [ADDR_W-1:0]         addr,
  input logic                      mem_read,
  input logic                      mem_write,
  input logic                      board_active,
  input logic                      phantom_n,
  input logic                      phantom_honor,
  input logic [NUM_WIN*BASE_W-1:0] win_base,
  input logic [NUM_WIN-1:0]        win_wr_en,
  input logic [NUM_WIN-1:0]        win_cs,
  input logic                      board_sel,
  input logic                      ram_we,
  input logic [IDX_W-1:0]          win_idx,
  input logic [WIN_ADDR_W-1:0]     ram_offset
);

  AST_CS_ONEHOT: assert property (@(posedge clk) disable iff (rst) $onehot0(win_cs)); // R3
  AST_SEL_MATCHES_CS: assert property (@(posedge clk) disable iff (rst) board_sel == (win_cs != '0)); // R2
  AST_WE_ONLY_ON_WRITE: assert property (@(posedge clk) disable iff (rst) ram_we |-> (board_sel && $past(mem_write))); // R5
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst) !(mem_read || mem_write) |=> !board_sel); // R9
  AST_INACTIVE_QUIET: assert property (@(posedge clk) disable iff (rst) !board_active |=> (!board_sel && !ram_we)); // R8
  AST_PHANTOM_QUIET: assert property (@(posedge clk) disable iff (rst) (phantom_honor && !phantom_n) |=> (!board_sel && !ram_we)); // R6
  AST_OFFSET_TRACKS: assert property (@(posedge clk) disable iff (rst) board_sel |-> ram_offset == $past(addr[WIN_ADDR_W-1:0])); // R4

  for (genvar k = 0; k < NUM_WIN; k++) begin : g_win
    AST_CS_BASE_MATCH: assert property (@(posedge clk) disable iff (rst) win_cs[k] |-> $past(addr[ADDR_W-1 -: BASE_W]) == $past(win_base[k*BASE_W +: BASE_W])); // R2
    AST_IDX_AGREES: assert property (@(posedge clk) disable iff (rst) win_cs[k] |-> win_idx == IDX_W'(k)); // R4
    AST_PROTECT: assert property (@(posedge clk) disable iff (rst) (win_cs[k] && ram_we) |-> $past(win_wr_en[k])); // R5
    if (k > 0) begin : g_prio
      AST_PRIORITY: assert property (@(posedge clk) disable iff (rst) win_cs[k] |-> $past(addr[ADDR_W-1 -: BASE_W]) != $past(win_base[(k-1)*BASE_W +: BASE_W])); // R3
    end
  end

endmodule

bind tri_window_decoder tri_window_decoder_chk #(
  .ADDR_W     (ADDR_W),
  .WIN_ADDR_W (WIN_ADDR_W),
  .NUM_WIN    (NUM_WIN)
) u_chk (.*);

// File: tb/tri_window_decoder_test.sv
module tri_window_decoder_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] addr = '0;
  logic        mem_read = 1'b0;
  logic        mem_write = 1'b0;
  logic        board_active = 1'b1;
  logic        phantom_n = 1'b1;
  logic        phantom_honor = 1'b0;
  logic [8:0]  win_base = 9'o321;
  logic [2:0]  win_wr_en = 3'b111;
  logic [2:0]  win_cs;
  logic        board_sel;
  logic        ram_we;
  logic [1:0]  win_idx;
  logic [12:0] ram_offset;

  logic [7:0]  wdata = '0;
  logic [7:0]  wdata_q;
  logic [7:0]  bram [3][256];

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  tri_window_decoder uut (
    .clk, .rst, .addr, .mem_read, .mem_write, .board_active, .phantom_n,
    .phantom_honor, .win_base, .win_wr_en, .win_cs, .board_sel, .ram_we,
    .win_idx, .ram_offset
  );

  // Bench-side RAM driven only by the decoder outputs.
  always_ff @(posedge clk) begin
    wdata_q <= wdata;
    if (ram_we && win_idx < 2'd3) bram[win_idx][ram_offset[7:0]] <= wdata_q;
  end

  function automatic logic [19:0] expect_out(input logic [15:0] a, input logic rd,
                                             input logic wr);
    logic [2:0] cs;
    logic [1:0] idx;
    logic       en;
    logic       sel;
    logic       we;
    cs  = '0;
    idx = '0;
    en  = board_active && !(phantom_honor && !phantom_n) && (rd || wr);
    for (int k = 2; k >= 0; k--) begin
      if (a[15:13] == win_base[k*3 +: 3]) begin
        cs = '0;
        cs[k] = 1'b1;
        idx = 2'(k);
      end
    end
    sel = en && (cs != '0);
    if (!sel) begin
      cs  = '0;
      idx = '0;
    end
    we = sel && wr && win_wr_en[idx];
    return {cs, sel, we, idx, a[12:0]};
  endfunction

  task automatic check(input string tag, input logic [19:0] act, input logic [19:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: outputs %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step(input logic [15:0] a, input logic rd, input logic wr,
                      input string tag);
    logic [19:0] e;
    @(negedge clk);
    addr = a;
    mem_read = rd;
    mem_write = wr;
    e = expect_out(a, rd, wr);
    @(negedge clk);
    check(tag, {win_cs, board_sel, ram_we, win_idx, ram_offset}, e);
  endtask

  task automatic report;
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not end, got timeout expected completion");
    report();
  end

  initial begin
    logic [8:0] cfg_base [5];
    logic [2:0] cfg_we [5];
    string tag;
    cfg_base[0] = 9'o321; cfg_we[0] = 3'b111;
    cfg_base[1] = 9'o555; cfg_we[1] = 3'b010;
    cfg_base[2] = 9'o070; cfg_we[2] = 3'b101;
    cfg_base[3] = 9'o464; cfg_we[3] = 3'b000;
    cfg_base[4] = 9'o012; cfg_we[4] = 3'b110;

    // R1: reset clears every output even with a live access applied
    addr = 16'h2ABC; mem_write = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1", {win_cs, board_sel, ram_we, win_idx, ram_offset}, 20'h0);
    rst = 1'b0;
    mem_write = 1'b0;

    // R2 R6 R7 R8 R9: sweep of pages, operations and gate settings
    for (int c = 0; c < 5; c++) begin
      win_base = cfg_base[c];
      win_wr_en = cfg_we[c];
      for (int g = 0; g < 8; g++) begin
        board_active = g[0];
        phantom_n = g[1];
        phantom_honor = g[2];
        for (int p = 0; p < 8; p++) begin
          for (int op = 0; op < 3; op++) begin
            if (!board_active) tag = "R8";
            else if (phantom_honor && !phantom_n) tag = "R6";
            else if (!phantom_honor && !phantom_n) tag = "R7";
            else if (op == 0) tag = "R9";
            else tag = "R2";
            step({3'(p), 13'((p * 1237 + c * 311 + op * 97) % 8192)},
                 op == 1, op == 2, tag);
          end
        end
      end
    end

    board_active = 1'b1; phantom_n = 1'b1; phantom_honor = 1'b0;
    win_wr_en = 3'b111;

    // R10: windows at 2000h, 4000h, 6000h
    win_base = 9'o321;
    step(16'h2000, 1, 0, "R10");
    step(16'h3FFF, 1, 0, "R10");
    step(16'h4000, 0, 1, "R10");
    step(16'h5FFF, 1, 0, "R10");
    step(16'h6000, 1, 0, "R10");
    step(16'h7FFF, 0, 1, "R10");
    step(16'h1FFF, 1, 0, "R10");
    step(16'h8000, 1, 0, "R10");

    // R3: overlapping bases resolve to the lowest index
    win_base = 9'o444;
    step(16'h8123, 1, 0, "R3");
    win_base = 9'o446;
    step(16'h8000, 0, 1, "R3");
    win_base = 9'o466;
    step(16'h9FFF, 1, 0, "R3");

    // R4: offset and index values
    win_base = 9'o523;
    step(16'h7ABC, 1, 0, "R4");
    step(16'h5013, 1, 0, "R4");
    step(16'hA001, 1, 0, "R4");

    // R5: protected window keeps its data and still answers reads
    win_base = 9'o321;
    wdata = 8'h5A;
    step(16'h4010, 0, 1, "R5");
    step(16'h0000, 0, 0, "R5");
    win_wr_en = 3'b101;
    wdata = 8'hA5;
    step(16'h4010, 0, 1, "R5");
    step(16'h0000, 0, 0, "R5");
    check("R5", {12'h0, bram[1][8'h10]}, {12'h0, 8'h5A});
    step(16'h4010, 1, 0, "R5");
    wdata = 8'h3C;
    step(16'h2010, 0, 1, "R5");
    step(16'h0000, 0, 0, "R5");
    check("R5", {12'h0, bram[0][8'h10]}, {12'h0, 8'h3C});

    report();
  end

endmodule